// File: doc/BRIEF.md
# Pipelined Multiply-Adder

This block takes up to four operand pairs per cycle, forms each product, and adds the products into one result. The products at odd positions (the second and the fourth) are either added or subtracted, as chosen by a run-time control. A second run-time control chooses whether all operands are read as two's complement or as unsigned numbers. Both controls may change on every cycle. They are carried down the pipeline next to the operands they apply to, so each result uses the controls that arrived with its own operands.

Build-time parameters set the operand width, the number of products, and the register stages. The input stage can be on or off. When it is on, it captures the operands, both controls and the valid flag together. The product stage can also be on or off. The result register is always present, and it can be followed by any number of extra delay stages. A chain option feeds each multiplier's A operand from the registered A operand of the multiplier below it, so that one A input stream is shared by all the multipliers. A valid flag travels with the data through the same stages. A synchronous clear zeroes every pipeline register.

Top module: `mac_sum_pipe`

## Requirements
- R1: Operand lane k sits in bits [k*WIDTH +: WIDTH] of `a_flat` and `b_flat`. The result is the sum over all lanes of a[k]*b[k]. Lanes 0 and 2 are always added. Lanes 1 and 3 are added when `sub_sel`=0 and subtracted when `sub_sel`=1. Any product count from 1 to 4 is allowed.
- R2: When `signed_sel`=1, the operands are read as two's complement. When `signed_sel`=0, they are read as unsigned and every product is non-negative.
- R3: `signed_sel` and `sub_sel` may change on any cycle. Each result uses the control values that were sampled together with its own operands.
- R4: The result is RW = 2*WIDTH + ceil(log2(NPROD)) bits wide and holds the exact sum with no overflow. An all-add unsigned sum reads as unsigned. Every other sum reads as two's complement.
- R5: The latency is LAT = (IN_REG or CHAIN_EN) + PROD_REG + 1 + EXTRA_LAT cycles. `out_valid` repeats `in_valid` exactly LAT cycles later.
- R6: While `sclr`=1, every pipeline register, including every valid bit, is cleared at the clock edge. `result` reads 0 and `out_valid` reads 0 until data captured after the clear reaches the output.
- R7: When CHAIN_EN=1, multiplier k (k>0) uses the lane-0 A operand that arrived k cycles before its own B operand. The A lanes above lane 0 are ignored. When CHAIN_EN=1, the input stage is always present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| sclr | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Marks the operands on this cycle as valid |
| signed_sel | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| sub_sel | input | 1 | 1 = subtract lanes 1 and 3, 0 = add them |
| a_flat | input | NPROD*WIDTH | A operands, lane k at bits [k*WIDTH +: WIDTH] |
| b_flat | input | NPROD*WIDTH | B operands, same layout as `a_flat` |
| out_valid | output | 1 | Valid flag, delayed by LAT cycles |
| result | output | RW | Sum of the products |

## Verification
The bench drives one set of operands at each falling edge. For each set it records the expected result and the expected valid flag, computed as exact integer arithmetic truncated to RW bits. On the main instance a result is due five cycles after its operands, because that instance has input, product, result and two extra stages. On the chain instance a result is due two cycles after its operands, because that instance has only input and result stages. At every falling edge, each instance's outputs are compared with the record made LAT falling edges earlier. When a clear is applied, the records still in flight are set to zero. Records from before the first operands count as zero, so the reset state is checked as well.

// File: rtl/mac_sum_pkg.sv
package mac_sum_pkg;

    // Extra bits the adder needs so that the sum of n products cannot overflow.
    function automatic int sum_growth(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // Result width for operand width w and product count n.
    function automatic int res_width(input int w, input int n);
        return 2 * w + sum_growth(n);
    endfunction

endpackage

// File: rtl/mac_delay.sv
module mac_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         sclr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_clk;
            assign unused_clk = clk ^ sclr;
            assign q = d;
        end else begin : g_regs
            logic [DEPTH-1:0][W-1:0] sr;
            always_ff @(posedge clk) begin
                if (sclr) begin
                    sr <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < DEPTH; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mac_in_stage.sv
module mac_in_stage #(
    parameter int WIDTH    = 16,
    parameter int NPROD    = 4,
    parameter int IN_REG   = 1,
    parameter int CHAIN_EN = 0
) (
    input  logic                        clk,
    input  logic                        sclr,
    input  logic [NPROD-1:0][WIDTH-1:0] a_in,
    input  logic [NPROD-1:0][WIDTH-1:0] b_in,
    input  logic                        sgn_in,
    input  logic                        sub_in,
    input  logic                        vld_in,
    output logic [NPROD-1:0][WIDTH-1:0] a_op,
    output logic [NPROD-1:0][WIDTH-1:0] b_op,
    output logic                        sgn_op,
    output logic                        sub_op,
    output logic                        vld_op
);
    // The chain needs the registered A operands, so chain mode forces the stage on.
    localparam bit HAS_REG = (IN_REG != 0) || (CHAIN_EN != 0);

    logic [NPROD-1:0][WIDTH-1:0] a_src;

    generate
        if (CHAIN_EN != 0) begin : g_chain
            logic [2:0] age;
            logic       unused_lanes;
            assign unused_lanes = ^a_in;
            assign a_src[0] = a_in[0];

            always_ff @(posedge clk) begin
                if (sclr)             age <= '0;
                else if (age < 3'd4)  age <= age + 3'd1;
            end

            for (genvar k = 1; k < NPROD; k++) begin : g_link
                assign a_src[k] = a_op[k-1];
                // Lane k holds the lane-0 A operand from k+1 clock edges earlier.
                assert_chain_delay_R7: assert property (
                    @(posedge clk) disable iff (sclr)
                    (age > k) |-> (a_op[k] == $past(a_in[0], k + 1))
                );
            end
        end else begin : g_direct
            assign a_src = a_in;
        end

        if (HAS_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (sclr) begin
                    a_op   <= '0;
                    b_op   <= '0;
                    sgn_op <= 1'b0;
                    sub_op <= 1'b0;
                    vld_op <= 1'b0;
                end else begin
                    a_op   <= a_src;
                    b_op   <= b_in;
                    sgn_op <= sgn_in;
                    sub_op <= sub_in;
                    vld_op <= vld_in;
                end
            end
        end else begin : g_pass
            logic unused_clk;
            assign unused_clk = clk ^ sclr;
            assign a_op   = a_src;
            assign b_op   = b_in;
            assign sgn_op = sgn_in;
            assign sub_op = sub_in;
            assign vld_op = vld_in;
        end
    endgenerate
endmodule

// File: rtl/mac_prod_stage.sv
module mac_prod_stage #(
    parameter int WIDTH    = 16,
    parameter int NPROD    = 4,
    parameter int PROD_REG = 1,
    parameter int PW       = 2 * WIDTH + 2
) (
    input  logic                        clk,
    input  logic                        sclr,
    input  logic [NPROD-1:0][WIDTH-1:0] a_in,
    input  logic [NPROD-1:0][WIDTH-1:0] b_in,
    input  logic                        sgn_in,
    input  logic                        sub_in,
    input  logic                        vld_in,
    output logic [NPROD-1:0][PW-1:0]    prod_q,
    output logic                        sgn_q,
    output logic                        sub_q,
    output logic                        vld_q
);
    logic [NPROD-1:0][PW-1:0] prod_c;
    logic [NPROD-1:0]         neg_bits;

    generate
        for (genvar k = 0; k < NPROD; k++) begin : g_mul
            logic signed [WIDTH:0] ae;
            logic signed [WIDTH:0] be;
            // One signed multiplier covers both modes: the extra top bit is the
            // sign bit when signed_sel is 1 and a zero when it is 0.
            assign ae = $signed({sgn_in & a_in[k][WIDTH-1], a_in[k]});
            assign be = $signed({sgn_in & b_in[k][WIDTH-1], b_in[k]});
            assign prod_c[k]   = ae * be;
            assign neg_bits[k] = prod_c[k][PW-1];
        end

        if (PROD_REG != 0) begin : g_reg
            always_ff @(posedge clk) begin
                if (sclr) begin
                    prod_q <= '0;
                    sgn_q  <= 1'b0;
                    sub_q  <= 1'b0;
                    vld_q  <= 1'b0;
                end else begin
                    prod_q <= prod_c;
                    sgn_q  <= sgn_in;
                    sub_q  <= sub_in;
                    vld_q  <= vld_in;
                end
            end
        end else begin : g_pass
            assign prod_q = prod_c;
            assign sgn_q  = sgn_in;
            assign sub_q  = sub_in;
            assign vld_q  = vld_in;
        end
    endgenerate

    assert_unsigned_prod_R2: assert property (
        @(posedge clk) disable iff (sclr)
        !sgn_in |-> (neg_bits == '0)
    );
endmodule

// File: rtl/mac_sum_stage.sv
module mac_sum_stage #(
    parameter int NPROD     = 4,
    parameter int PW        = 34,
    parameter int RW        = 34,
    parameter int EXTRA_LAT = 1
) (
    input  logic                     clk,
    input  logic                     sclr,
    input  logic [NPROD-1:0][PW-1:0] prod_in,
    input  logic                     sgn_in,
    input  logic                     sub_in,
    input  logic                     vld_in,
    output logic [RW-1:0]            result,
    output logic                     out_valid
);
    localparam int SW = PW + 2;

    logic signed [SW-1:0] wide;
    logic                 fits;
    logic [RW-1:0]        res_q;
    logic                 vld_q;

    always_comb begin
        wide = '0;
        for (int k = 0; k < NPROD; k++) begin
            if (((k % 2) == 1) && sub_in) begin
                wide = wide - $signed({{2{prod_in[k][PW-1]}}, prod_in[k]});
            end else begin
                wide = wide + $signed({{2{prod_in[k][PW-1]}}, prod_in[k]});
            end
        end
    end

    // The sum fits in RW bits, as two's complement or as an all-add unsigned sum.
    always_comb begin
        fits = (&wide[SW-1:RW-1]) || !(|wide[SW-1:RW-1])
            || (!sgn_in && !sub_in && (wide[SW-1:RW] == '0));
    end

    always_ff @(posedge clk) begin
        if (sclr) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            res_q <= wide[RW-1:0];
            vld_q <= vld_in;
        end
    end

    mac_delay #(.W(RW + 1), .DEPTH(EXTRA_LAT)) u_tail (
        .clk  (clk),
        .sclr (sclr),
        .d    ({vld_q, res_q}),
        .q    ({out_valid, result})
    );

    assert_no_overflow_R4: assert property (
        @(posedge clk) disable iff (sclr) fits
    );

    assert_clear_result_R6: assert property (
        @(posedge clk) disable iff (sclr)
        $past(sclr) |-> ((res_q == '0) && !vld_q)
    );
endmodule

// File: rtl/mac_sum_pipe.sv
module mac_sum_pipe
    import mac_sum_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int NPROD     = 4,
    parameter int IN_REG    = 1,
    parameter int PROD_REG  = 1,
    parameter int EXTRA_LAT = 1,
    parameter int CHAIN_EN  = 0
) (
    input  logic                                   clk,
    input  logic                                   sclr,
    input  logic                                   in_valid,
    input  logic                                   signed_sel,
    input  logic                                   sub_sel,
    input  logic [NPROD*WIDTH-1:0]                 a_flat,
    input  logic [NPROD*WIDTH-1:0]                 b_flat,
    output logic                                   out_valid,
    output logic [res_width(WIDTH, NPROD)-1:0]     result
);
    localparam int RW  = res_width(WIDTH, NPROD);
    localparam int PW  = 2 * WIDTH + 2;
    localparam int LAT = (((IN_REG != 0) || (CHAIN_EN != 0)) ? 1 : 0)
                       + ((PROD_REG != 0) ? 1 : 0) + 1 + EXTRA_LAT;
    localparam int CW  = $clog2(LAT + 1) + 1;

    logic [NPROD-1:0][WIDTH-1:0] a_op, b_op;
    logic                        sgn_op, sub_op, vld_op;
    logic [NPROD-1:0][PW-1:0]    prod;
    logic                        sgn_p, sub_p, vld_p;
    logic [CW-1:0]               lat_cnt;

    mac_in_stage #(
        .WIDTH(WIDTH), .NPROD(NPROD), .IN_REG(IN_REG), .CHAIN_EN(CHAIN_EN)
    ) u_in (
        .clk    (clk),
        .sclr   (sclr),
        .a_in   (a_flat),
        .b_in   (b_flat),
        .sgn_in (signed_sel),
        .sub_in (sub_sel),
        .vld_in (in_valid),
        .a_op   (a_op),
        .b_op   (b_op),
        .sgn_op (sgn_op),
        .sub_op (sub_op),
        .vld_op (vld_op)
    );

    mac_prod_stage #(
        .WIDTH(WIDTH), .NPROD(NPROD), .PROD_REG(PROD_REG), .PW(PW)
    ) u_prod (
        .clk    (clk),
        .sclr   (sclr),
        .a_in   (a_op),
        .b_in   (b_op),
        .sgn_in (sgn_op),
        .sub_in (sub_op),
        .vld_in (vld_op),
        .prod_q (prod),
        .sgn_q  (sgn_p),
        .sub_q  (sub_p),
        .vld_q  (vld_p)
    );

    mac_sum_stage #(
        .NPROD(NPROD), .PW(PW), .RW(RW), .EXTRA_LAT(EXTRA_LAT)
    ) u_sum (
        .clk       (clk),
        .sclr      (sclr),
        .prod_in   (prod),
        .sgn_in    (sgn_p),
        .sub_in    (sub_p),
        .vld_in    (vld_p),
        .result    (result),
        .out_valid (out_valid)
    );

    // Cycles since the last clear, saturating at the pipeline latency.
    always_ff @(posedge clk) begin
        if (sclr)                   lat_cnt <= '0;
        else if (lat_cnt < CW'(LAT)) lat_cnt <= lat_cnt + 1'b1;
    end

    assert_valid_latency_R5: assert property (
        @(posedge clk) disable iff (sclr)
        out_valid |-> (lat_cnt >= CW'(LAT))
    );
endmodule

// File: tb/mac_sum_pipe_tb.sv
`timescale 1ns/1ps
module mac_sum_pipe_tb_top;
    localparam int W      = 3;
    localparam int LAT_A  = 5;
    localparam int LAT_B  = 2;
    localparam int NSTEP  = 512;
    localparam int CLR_AT = 300;
    localparam int NREC   = NSTEP + 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               sclr, in_valid, sgn, sub;
    logic [3:0][W-1:0]  a_l, b_l;
    logic [7:0]         res_a, res_b;
    logic               ov_a, ov_b;

    logic [7:0] exp_a [0:NREC-1];
    logic [7:0] exp_b [0:NREC-1];
    bit         v_a   [0:NREC-1];
    bit         v_b   [0:NREC-1];
    bit         z_a   [0:NREC-1];
    bit         z_b   [0:NREC-1];
    logic [W-1:0] hist [0:NREC+3];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    mac_sum_pipe #(
        .WIDTH(W), .NPROD(4), .IN_REG(1), .PROD_REG(1), .EXTRA_LAT(2), .CHAIN_EN(0)
    ) dut_i (
        .clk(clk), .sclr(sclr), .in_valid(in_valid), .signed_sel(sgn), .sub_sel(sub),
        .a_flat(a_l), .b_flat(b_l), .out_valid(ov_a), .result(res_a)
    );

    mac_sum_pipe #(
        .WIDTH(W), .NPROD(3), .IN_REG(0), .PROD_REG(0), .EXTRA_LAT(0), .CHAIN_EN(1)
    ) dut_chain_i (
        .clk(clk), .sclr(sclr), .in_valid(in_valid), .signed_sel(sgn), .sub_sel(sub),
        .a_flat(a_l[2:0]), .b_flat(b_l[2:0]), .out_valid(ov_b), .result(res_b)
    );

    function automatic longint pv(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
        longint x, y;
        x = s ? longint'($signed(a)) : longint'(a);
        y = s ? longint'($signed(b)) : longint'(b);
        return x * y;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, NSTEP + 16);
                finish_run();
            end
        end
    end

    initial begin
        sclr = 1'b1; in_valid = 1'b0; sgn = 1'b0; sub = 1'b0;
        a_l = '0; b_l = '0;
        for (int i = 0; i < NREC + 4; i++) hist[i] = '0;
        repeat (3) @(posedge clk);

        for (int s = 0; s < NSTEP + LAT_A; s++) begin
            @(negedge clk);
            // Main instance: R1/R2/R3/R4 on the sum, R5 on valid, R6 after a clear.
            if (s < LAT_A || z_a[s-LAT_A]) begin
                chk("R6 main result after clear", res_a, 8'h00);
                chk("R6 main valid after clear", {7'd0, ov_a}, 8'h00);
            end else begin
                chk("R1/R2/R3/R4 main result", res_a, exp_a[s-LAT_A]);
                chk("R5 main valid", {7'd0, ov_a}, {7'd0, v_a[s-LAT_A]});
            end
            // Chain instance: R7 on the sum, R5 on its shorter latency.
            if (s < LAT_B || z_b[s-LAT_B]) begin
                chk("R6 chain result after clear", res_b, 8'h00);
                chk("R6 chain valid after clear", {7'd0, ov_b}, 8'h00);
            end else begin
                chk("R7 chain result", res_b, exp_b[s-LAT_B]);
                chk("R5 chain valid", {7'd0, ov_b}, {7'd0, v_b[s-LAT_B]});
            end

            if (s < NSTEP) begin
                logic [7:0] idx;
                idx = 8'(s);
                sclr     = (s == CLR_AT);
                sgn      = idx[0];
                sub      = idx[1];
                a_l[0]   = idx[4:2];
                b_l[0]   = idx[7:5];
                for (int k = 1; k < 4; k++) begin
                    a_l[k] = W'($urandom);
                    b_l[k] = W'($urandom);
                end
                in_valid = (($urandom % 4) != 0);
            end else begin
                sclr = 1'b0; in_valid = 1'b0;
                a_l = '0; b_l = '0;
            end

            hist[s+4] = a_l[0];
            if (sclr) begin
                for (int j = s - LAT_A + 1; j <= s; j++)
                    if (j >= 0) begin exp_a[j] = '0; v_a[j] = 1'b0; z_a[j] = 1'b1; end
                for (int j = s - LAT_B + 1; j <= s; j++)
                    if (j >= 0) begin exp_b[j] = '0; v_b[j] = 1'b0; z_b[j] = 1'b1; end
                for (int j = s + 1; j <= s + 4; j++) hist[j] = '0;
            end else begin
                longint acc;
                acc = 0;
                for (int k = 0; k < 4; k++) begin
                    longint p;
                    p = pv(a_l[k], b_l[k], sgn);
                    acc = ((k % 2) == 1 && sub) ? acc - p : acc + p;
                end
                exp_a[s] = acc[7:0]; v_a[s] = in_valid; z_a[s] = 1'b0;
                acc = 0;
                for (int k = 0; k < 3; k++) begin
                    longint p;
                    // R7: lane k takes the lane-0 A operand from k steps earlier.
                    p = pv(hist[s+4-k], b_l[k], sgn);
                    acc = ((k % 2) == 1 && sub) ? acc - p : acc + p;
                end
                exp_b[s] = acc[7:0]; v_b[s] = in_valid; z_b[s] = 1'b0;
            end
        end
        finish_run();
    end
endmodule